// File: doc/BRIEF.md
# Handshake Bus Clock-Domain Crossing

This block carries a data word of any bit pattern from a source clock domain into a destination clock domain. The two clocks may be unrelated, and either may be the faster one. The source side takes a word into a holding register and raises a request. The request passes through a synchronizer into the destination domain. The destination then copies the held word and presents it with a valid strobe. An acknowledge travels back through a second synchronizer. Both request and acknowledge must return to zero before the source reports itself ready again. The result is a complete four-phase exchange for every word.

Each synchronizer chain has its own depth parameter. A mode parameter chooses who acknowledges in the destination domain. In external mode, the consumer answers through `dst_take`. In internal mode, the block acknowledges by itself and the consumer must take the word in the one cycle that valid is high.

Top module: `hs_cdc_bus`

## Requirements
- R1: After reset, `src_ready` is 1 and `dst_valid` is 0.
- R2: Every word accepted at the source appears at `dst_word` exactly once, unchanged and in acceptance order. Any bit pattern is allowed, whatever the number of bits that differ from the previous word.
- R3: A word is accepted on a `src_clk` edge where `src_send` and `src_ready` are both 1. `src_ready` is 0 from the next cycle onward. `src_send` and `src_word` have no effect while `src_ready` is 0.
- R4: `src_ready` returns to 1 only after the synchronized acknowledge has gone high and then low again. The busy time is therefore at least twice the acknowledge synchronizer depth in source cycles.
- R5: In external mode (`SELF_ACK`=0), `dst_valid` stays at 1 and `dst_word` stays constant until a `dst_clk` edge that sees `dst_take` at 1. `dst_valid` is 0 in the next cycle.
- R6: In internal mode (`SELF_ACK`=1), `dst_valid` is high for exactly one `dst_clk` cycle per word and `dst_take` has no effect.
- R7: `REQ_STAGES` and `ACK_STAGES` set the request and acknowledge synchronizer depths independently. Each must be at least 2.
- R8: Transfers are correct both when the destination clock is faster than the source clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_send | input | 1 | Launch a transfer of `src_word` |
| src_word | input | DATA_W | Word to be carried |
| src_ready | output | 1 | Source idle; a launch will be accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_word | output | DATA_W | Delivered word |
| dst_valid | output | 1 | `dst_word` holds a new word |
| dst_take | input | 1 | Consumer acknowledge (external mode only) |

## Verification
Two events can meet in one source cycle: a retry of `src_send` with a different word, and the busy phase of the transfer before it. The bench drives such a retry in the cycle right after each accepted word. It then judges the result in two places: `src_ready` must already read 0, and the stray word must never reach the destination scoreboard. On the destination side, a random consumer delay makes `dst_take` fall either in the first cycle of `dst_valid` or many cycles later. In internal mode it is driven at random and must change nothing.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_REQ   = 2'd1,
        SRC_DRAIN = 2'd2
    } src_state_e;

    typedef enum logic [1:0] {
        DST_IDLE    = 2'd0,
        DST_SHOW    = 2'd1,
        DST_RELEASE = 2'd2
    } dst_state_e;

    localparam int MIN_SYNC_STAGES = 2;

    function automatic bit depth_ok(input int stages);
        return stages >= MIN_SYNC_STAGES;
    endfunction

endpackage

// File: rtl/hs_cdc_sync.sv
module hs_cdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_cdc_src.sv
module hs_cdc_src
    import hs_cdc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [DATA_W-1:0] word_in,
    input  logic              ack_in,
    output logic              ready,
    output logic              req_out,
    output logic [DATA_W-1:0] hold_out
);
    src_state_e        state;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SRC_IDLE;
            req_out <= 1'b0;
            hold_q  <= '0;
        end else begin
            unique case (state)
                SRC_IDLE: if (send) begin
                    hold_q  <= word_in;
                    req_out <= 1'b1;
                    state   <= SRC_REQ;
                end
                SRC_REQ: if (ack_in) begin
                    req_out <= 1'b0;
                    state   <= SRC_DRAIN;
                end
                SRC_DRAIN: if (!ack_in) state <= SRC_IDLE;
                default: state <= SRC_IDLE;
            endcase
        end
    end

    assign ready    = (state == SRC_IDLE);
    assign hold_out = hold_q;
endmodule

// File: rtl/hs_cdc_dst.sv
module hs_cdc_dst
    import hs_cdc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter bit SELF_ACK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic [DATA_W-1:0] hold_in,
    input  logic              take,
    output logic [DATA_W-1:0] word_out,
    output logic              valid,
    output logic              ack_out
);
    dst_state_e        state;
    logic [DATA_W-1:0] word_q;
    logic              take_eff;

    generate
        if (SELF_ACK) begin : g_self
            assign take_eff = 1'b1 | take;
        end else begin : g_ext
            assign take_eff = take;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DST_IDLE;
            word_q  <= '0;
            ack_out <= 1'b0;
        end else begin
            unique case (state)
                DST_IDLE: if (req_in) begin
                    word_q <= hold_in;
                    state  <= DST_SHOW;
                end
                DST_SHOW: if (take_eff) begin
                    ack_out <= 1'b1;
                    state   <= DST_RELEASE;
                end
                DST_RELEASE: if (!req_in) begin
                    ack_out <= 1'b0;
                    state   <= DST_IDLE;
                end
                default: state <= DST_IDLE;
            endcase
        end
    end

    assign valid    = (state == DST_SHOW);
    assign word_out = word_q;
endmodule

// File: rtl/hs_cdc_bus.sv
module hs_cdc_bus
    import hs_cdc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int REQ_STAGES = 2,
    parameter int ACK_STAGES = 2,
    parameter bit SELF_ACK   = 1'b0
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_send,
    input  logic [DATA_W-1:0] src_word,
    output logic              src_ready,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic [DATA_W-1:0] dst_word,
    output logic              dst_valid,
    input  logic              dst_take
);
    logic              req_line;
    logic              req_at_dst;
    logic              ack_line;
    logic              ack_at_src;
    logic [DATA_W-1:0] hold_bus;

    initial begin
        if (!depth_ok(REQ_STAGES)) $error("REQ_STAGES below minimum");
        if (!depth_ok(ACK_STAGES)) $error("ACK_STAGES below minimum");
    end

    hs_cdc_src #(.DATA_W(DATA_W)) u_src (
        .clk(src_clk), .rst(src_rst), .send(src_send), .word_in(src_word),
        .ack_in(ack_at_src), .ready(src_ready), .req_out(req_line),
        .hold_out(hold_bus)
    );

    hs_cdc_sync #(.STAGES(REQ_STAGES)) u_req_sync (
        .clk(dst_clk), .rst(dst_rst), .d(req_line), .q(req_at_dst)
    );

    hs_cdc_dst #(.DATA_W(DATA_W), .SELF_ACK(SELF_ACK)) u_dst (
        .clk(dst_clk), .rst(dst_rst), .req_in(req_at_dst), .hold_in(hold_bus),
        .take(dst_take), .word_out(dst_word), .valid(dst_valid),
        .ack_out(ack_line)
    );

    hs_cdc_sync #(.STAGES(ACK_STAGES)) u_ack_sync (
        .clk(src_clk), .rst(src_rst), .d(ack_line), .q(ack_at_src)
    );
endmodule

// File: rtl/hs_cdc_chk.sv
module hs_cdc_chk #(
    parameter int DATA_W   = 16,
    parameter bit SELF_ACK = 1'b0
) (
    input logic              src_clk,
    input logic              src_rst,
    input logic              src_send,
    input logic              src_ready,
    input logic              req_line,
    input logic              ack_at_src,
    input logic              dst_clk,
    input logic              dst_rst,
    input logic              dst_valid,
    input logic              dst_take,
    input logic [DATA_W-1:0] dst_word,
    input logic              req_at_dst,
    input logic              ack_line
);
    // R3: an accepted launch makes the source busy in the next cycle
    p_busy_after_send_r3: assert property (@(posedge src_clk) disable iff (src_rst)
        (src_ready && src_send) |=> !src_ready);

    // R4: ready never comes back while the returned acknowledge is still high
    p_ready_after_ack_low_r4: assert property (@(posedge src_clk) disable iff (src_rst)
        $rose(src_ready) |-> !ack_at_src);

    // R4: request is only withdrawn once acknowledge has been seen
    p_req_drop_on_ack_r4: assert property (@(posedge src_clk) disable iff (src_rst)
        $fell(req_line) |-> $past(ack_at_src));

    // R4: destination acknowledges only a request it currently sees
    p_ack_follows_req_r4: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $rose(ack_line) |-> $past(req_at_dst));

    generate
        if (SELF_ACK) begin : g_self
            // R6: valid is a single-cycle strobe
            p_valid_pulse_r6: assert property (@(posedge dst_clk) disable iff (dst_rst)
                dst_valid |=> !dst_valid);
        end else begin : g_ext
            // R5: word and valid held until the consumer takes it
            p_hold_until_take_r5: assert property (@(posedge dst_clk) disable iff (dst_rst)
                (dst_valid && !dst_take) |=> (dst_valid && $stable(dst_word)));
            // R5: valid drops right after the take
            p_drop_after_take_r5: assert property (@(posedge dst_clk) disable iff (dst_rst)
                (dst_valid && dst_take) |=> !dst_valid);
        end
    endgenerate
endmodule

bind hs_cdc_bus hs_cdc_chk #(.DATA_W(DATA_W), .SELF_ACK(SELF_ACK)) u_chk (
    .src_clk(src_clk), .src_rst(src_rst), .src_send(src_send),
    .src_ready(src_ready), .req_line(req_line), .ack_at_src(ack_at_src),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_valid(dst_valid),
    .dst_take(dst_take), .dst_word(dst_word), .req_at_dst(req_at_dst),
    .ack_line(ack_line)
);

// File: tb/hs_cdc_bus_test.sv
module hs_cdc_bus_test;
    localparam int W      = 16;
    localparam int ACK_A  = 2;
    localparam int ACK_B  = 4;
    localparam int NWORDS = 40;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst = 1'b1;
    logic dst_rst = 1'b1;
    int   dst_half = 7;

    always #10 src_clk = ~src_clk;
    always begin
        #(dst_half);
        dst_clk = ~dst_clk;
    end

    // instance A: external acknowledge, REQ 3 / ACK 2 (R7)
    logic         a_send = 1'b0, a_ready, a_valid, a_take = 1'b0;
    logic [W-1:0] a_word = '0, a_out;
    // instance B: internal acknowledge, REQ 2 / ACK 4 (R7)
    logic         b_send = 1'b0, b_ready, b_valid, b_take = 1'b0;
    logic [W-1:0] b_word = '0, b_out;

    hs_cdc_bus #(.DATA_W(W), .REQ_STAGES(3), .ACK_STAGES(ACK_A), .SELF_ACK(1'b0)) uut (
        .src_clk(src_clk), .src_rst(src_rst), .src_send(a_send), .src_word(a_word),
        .src_ready(a_ready), .dst_clk(dst_clk), .dst_rst(dst_rst),
        .dst_word(a_out), .dst_valid(a_valid), .dst_take(a_take)
    );

    hs_cdc_bus #(.DATA_W(W), .REQ_STAGES(2), .ACK_STAGES(ACK_B), .SELF_ACK(1'b1)) uut_self (
        .src_clk(src_clk), .src_rst(src_rst), .src_send(b_send), .src_word(b_word),
        .src_ready(b_ready), .dst_clk(dst_clk), .dst_rst(dst_rst),
        .dst_word(b_out), .dst_valid(b_valid), .dst_take(b_take)
    );

    int checks = 0;
    int fails  = 0;
    int got_a  = 0;
    int got_b  = 0;
    int sent_a = 0;
    int sent_b = 0;
    logic [W-1:0] qa[$];
    logic [W-1:0] qb[$];
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] pick_word(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h5555;
            3: return 16'hAAAA;
            4: return 16'h8001;
            default: return W'($urandom);
        endcase
    endfunction

    // source driver; inst 0 = A, 1 = B
    task automatic push(input int inst, input logic [W-1:0] w);
        int busy = 0;
        int min_busy = 2 * ((inst == 0) ? ACK_A : ACK_B);
        if (inst == 0) while (!a_ready) @(negedge src_clk);
        else           while (!b_ready) @(negedge src_clk);
        if (inst == 0) begin a_send = 1'b1; a_word = w; qa.push_back(w); sent_a++; end
        else           begin b_send = 1'b1; b_word = w; qb.push_back(w); sent_b++; end
        @(negedge src_clk);
        // R3: busy right after acceptance; a stray launch with a different word
        if (inst == 0) begin
            check(a_ready == 1'b0, "R3 ready low after send", W'(a_ready), '0);
            a_word = ~w;
        end else begin
            check(b_ready == 1'b0, "R3 ready low after send", W'(b_ready), '0);
            b_word = ~w;
        end
        @(negedge src_clk);
        busy = 2;
        if (inst == 0) a_send = 1'b0; else b_send = 1'b0;
        while (((inst == 0) ? a_ready : b_ready) == 1'b0) begin
            @(negedge src_clk);
            busy++;
        end
        // R4: full return-to-zero exchange takes at least two ack-sync passes
        check(busy >= min_busy, "R4 busy span", W'(busy), W'(min_busy));
        repeat ($urandom % 3) @(negedge src_clk);
    endtask

    // destination monitor, external mode (R2, R5)
    bit a_seen = 1'b0, a_take_prev = 1'b0;
    logic [W-1:0] a_last = '0;
    always @(negedge dst_clk) begin
        if (!dst_rst) begin
            if (a_take_prev) check(a_valid == 1'b0, "R5 valid drops after take", W'(a_valid), '0);
            if (a_valid && !a_take_prev) begin
                if (!a_seen) begin
                    if (qa.size() == 0) check(1'b0, "R2 unexpected word A", a_out, '0);
                    else begin
                        check(a_out == qa[0], "R2/R8 word order A", a_out, qa[0]);
                        void'(qa.pop_front());
                    end
                    got_a++;
                    a_seen = 1'b1;
                    a_last = a_out;
                end else begin
                    check(a_out == a_last, "R5 word held while waiting", a_out, a_last);
                end
            end
            if (!a_valid) a_seen = 1'b0;
            a_take_prev = a_take;
            a_take = a_valid && !a_take_prev && ($urandom % 4 == 0);
            if (a_take) a_seen = 1'b0;
        end
    end

    // destination monitor, internal mode (R2, R6)
    bit b_prev_valid = 1'b0;
    always @(negedge dst_clk) begin
        if (!dst_rst) begin
            if (b_valid) begin
                check(!b_prev_valid, "R6 single-cycle valid", W'(b_prev_valid), '0);
                if (qb.size() == 0) check(1'b0, "R2 unexpected word B", b_out, '0);
                else begin
                    check(b_out == qb[0], "R2/R8 word order B", b_out, qb[0]);
                    void'(qb.pop_front());
                end
                got_b++;
            end
            b_prev_valid = b_valid;
            b_take = W'($urandom) % 2 == 1;   // R6: ignored in this mode
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", got_a + got_b, 4 * NWORDS);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge src_clk);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        @(negedge src_clk);
        // R1: reset state
        check(a_ready == 1'b1, "R1 ready after reset", W'(a_ready), 1);
        check(b_ready == 1'b1, "R1 ready after reset", W'(b_ready), 1);
        check(a_valid == 1'b0, "R1 valid after reset", W'(a_valid), 0);
        check(b_valid == 1'b0, "R1 valid after reset", W'(b_valid), 0);

        // R8: destination faster, then slower
        for (int phase = 0; phase < 2; phase++) begin
            dst_half = (phase == 0) ? 7 : 33;
            fork
                for (int i = 0; i < NWORDS; i++) push(0, pick_word(i));
                for (int i = 0; i < NWORDS; i++) push(1, pick_word(i + 1));
            join
            repeat (40) @(negedge src_clk);
        end

        check(got_a == sent_a, "R2 count A exactly once", W'(got_a), W'(sent_a));
        check(got_b == sent_b, "R2 count B exactly once", W'(got_b), W'(sent_b));
        check(qa.size() == 0, "R2 nothing pending A", W'(qa.size()), 0);
        check(qb.size() == 0, "R2 nothing pending B", W'(qb.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule